// File: doc/BRIEF.md
# Byte Logic and Rotate Unit

This unit is the byte-wide logic stage of an 8-bit controller's datapath. A decoder upstream hands it a decoded operation, the operand values it has already fetched, a destination choice and a one-cycle strobe. The unit returns the new byte, the new carry and separate write enables for the accumulator, the directly addressed location and the carry flag. All of these are registered and appear one clock after the strobe.

Two-operand operations are AND, OR and XOR. Their first operand is the accumulator, or the original contents of the direct destination when that destination is selected, so the unit performs a read-modify-write. When the direct destination is an I/O port, the first operand is taken from the port's output latch. When a port is only the second operand, its pin values are used. Single-operand operations work only on the accumulator: complement, clear, the 8-bit rotates, the 9-bit rotates through carry, and the nibble swap. The carry is written only by a rotate through carry, or when a two-operand result lands in the status word. In the second case the new carry is result bit 7.

Top module: `byte_logic_unit`

## Requirements
- R1: Op codes 0, 1 and 2 give, per bit, AND, OR and XOR of the first operand with the second operand.
- R2: Op code 3 gives the bitwise complement of the accumulator and op code 4 gives zero.
- R3: Op code 5 rotates the accumulator left with bit 7 going to bit 0. Op code 6 rotates it right with bit 0 going to bit 7. Neither raises `carry_we`, and both return `carry_out` equal to `carry_in`.
- R4: Op code 7 rotates left through carry: the result is {acc[6:0], carry_in} and `carry_out` is acc[7]. Op code 8 rotates right through carry: the result is {carry_in, acc[7:1]} and `carry_out` is acc[0]. Both raise `carry_we`.
- R5: Op code 9 exchanges bits 7:4 with bits 3:0 of the accumulator.
- R6: Op codes 3 to 9 ignore the second operand and `dst_direct`. They always write the accumulator (`acc_we`=1, `dst_we`=0).
- R7: `src_sel` picks the second operand: 0 selects the immediate, 1 the register, 2 the direct byte and 3 the indirect byte. With `src_sel`=2 and `src_dir_is_port`=1, the value comes from `src_pins`.
- R8: A two-operand operation with `dst_direct`=1 takes its first operand from `dst_mem_in`, or from `dst_latch_in` when `dst_is_port`=1.
- R9: A two-operand operation writes the accumulator when `dst_direct`=0 and the direct location when `dst_direct`=1. `acc_we` and `dst_we` are never high together.
- R10: A two-operand operation raises `carry_we` only when `dst_direct`=1 and `dst_is_status`=1, and then `carry_out` equals result bit 7. Otherwise `carry_out` equals `carry_in`.
- R11: Result, carry and enables appear one clock after an `op_valid` strobe, with `res_valid` high for that one cycle. A cycle with no strobe leaves every enable low on the next cycle.
- R12: Synchronous active-low reset clears all outputs. Op codes 10 to 15 raise no enable and no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation (0 to 9 legal) |
| dst_direct | input | 1 | 1: direct-address destination, 0: accumulator |
| dst_is_port | input | 1 | Direct destination is a port register |
| dst_is_status | input | 1 | Direct destination is the status word |
| src_sel | input | 2 | Second operand source: 0 imm, 1 reg, 2 direct, 3 indirect |
| acc_in | input | 8 | Current accumulator |
| dst_mem_in | input | 8 | Current contents of the direct destination |
| dst_latch_in | input | 8 | Output latch of the destination port |
| src_imm | input | 8 | Immediate operand |
| src_reg | input | 8 | Register operand |
| src_dir | input | 8 | Direct-address operand |
| src_ind | input | 8 | Indirect-address operand |
| src_dir_is_port | input | 1 | Direct source is a port |
| src_pins | input | 8 | Pin values of the source port |
| carry_in | input | 1 | Current carry flag |
| res_valid | output | 1 | Result valid, one cycle per operation |
| result | output | 8 | Registered result byte |
| carry_out | output | 1 | Registered carry value |
| acc_we | output | 1 | Write result to accumulator |
| dst_we | output | 1 | Write result to direct destination |
| carry_we | output | 1 | Write carry_out to the carry flag |

## Verification
Every result, carry value and enable is due exactly one clock after the rising edge that samples `op_valid`. The bench applies inputs at the falling edge and compares all outputs at the next falling edge, so each check falls midway through the cycle in which that operation's registered values are held. Operations are issued back to back, one per cycle, so a stale value or a one-cycle slip fails the following comparison. Idle and illegal-op cycles are checked at the same offset: enables must be low and `result` must still hold the previous value.

// File: rtl/blu_pkg.sv
// Package: shared operation and source encodings for the byte logic unit.
// Assumes op codes above OP_SWAP are illegal and are dropped by the unit.
package blu_pkg;

    localparam int unsigned OP_W  = 4;
    localparam int unsigned SRC_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_AND  = 4'd0,
        OP_OR   = 4'd1,
        OP_XOR  = 4'd2,
        OP_CPL  = 4'd3,
        OP_CLR  = 4'd4,
        OP_RL   = 4'd5,
        OP_RR   = 4'd6,
        OP_RLC  = 4'd7,
        OP_RRC  = 4'd8,
        OP_SWAP = 4'd9
    } op_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_IMM = 2'd0,
        SRC_REG = 2'd1,
        SRC_DIR = 2'd2,
        SRC_IND = 2'd3
    } src_e;

    // True for the encodings the unit executes.
    function automatic logic op_is_legal(input logic [OP_W-1:0] op);
        return op <= OP_W'(OP_SWAP);
    endfunction

    // True for the two-operand logic operations.
    function automatic logic op_is_binary(input logic [OP_W-1:0] op);
        return op <= OP_W'(OP_XOR);
    endfunction

    // True for the rotates that pass through carry.
    function automatic logic op_uses_carry(input logic [OP_W-1:0] op);
        return (op == OP_W'(OP_RLC)) || (op == OP_W'(OP_RRC));
    endfunction

endpackage

// File: rtl/blu_operand_sel.sv
// Module: blu_operand_sel
// Selects both operands of the logic core.
// First operand: the accumulator, unless a two-operand operation targets a
// direct address. A port destination then supplies its output latch and any
// other direct destination supplies its memory contents.
// Second operand: one of four sources. A direct source that is a port
// supplies its pin values.
// Assumes all inputs are stable for the cycle of the strobe.
module blu_operand_sel
    import blu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             is_binary,
    input  logic             dst_direct,
    input  logic             dst_is_port,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [W-1:0]     acc_in,
    input  logic [W-1:0]     dst_mem_in,
    input  logic [W-1:0]     dst_latch_in,
    input  logic [W-1:0]     src_imm,
    input  logic [W-1:0]     src_reg,
    input  logic [W-1:0]     src_dir,
    input  logic [W-1:0]     src_ind,
    input  logic             src_dir_is_port,
    input  logic [W-1:0]     src_pins,
    output logic [W-1:0]     lhs,
    output logic [W-1:0]     rhs
);

    logic [W-1:0] dst_orig;

    // Original value of the direct destination: latch for ports, else memory.
    always_comb begin
        dst_orig = dst_is_port ? dst_latch_in : dst_mem_in;
    end

    // First operand: read-modify-write only for two-operand ops to a direct target.
    always_comb begin
        lhs = (is_binary && dst_direct) ? dst_orig : acc_in;
    end

    // Second operand: source multiplexer, with pins for a port source.
    always_comb begin
        unique case (src_e'(src_sel))
            SRC_IMM: rhs = src_imm;
            SRC_REG: rhs = src_reg;
            SRC_DIR: rhs = src_dir_is_port ? src_pins : src_dir;
            SRC_IND: rhs = src_ind;
            default: rhs = src_imm;
        endcase
    end

endmodule

// File: rtl/blu_logic_core.sv
// Module: blu_logic_core
// Combinational logic, rotate and half-swap of one W-bit byte.
// The carry passes through unchanged except for the two carry rotates.
// Assumes W is even, so that the swap halves are equal.
module blu_logic_core
    import blu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [W-1:0]    lhs,
    input  logic [W-1:0]    rhs,
    input  logic            cin,
    output logic [W-1:0]    res,
    output logic            cout
);

    localparam int unsigned HALF = W / 2;

    logic [W-1:0] swapped;

    // Half exchange built bit by bit: bit i takes bit (i + HALF) mod W.
    for (genvar i = 0; i < W; i++) begin : g_swap
        assign swapped[i] = lhs[(i + HALF) % W];
    end

    // Operation select for the result byte and the carry.
    always_comb begin
        res  = lhs;
        cout = cin;
        unique case (op_e'(op))
            OP_AND:  res = lhs & rhs;
            OP_OR:   res = lhs | rhs;
            OP_XOR:  res = lhs ^ rhs;
            OP_CPL:  res = ~lhs;
            OP_CLR:  res = '0;
            OP_RL:   res = {lhs[W-2:0], lhs[W-1]};
            OP_RR:   res = {lhs[0], lhs[W-1:1]};
            OP_RLC: begin
                res  = {lhs[W-2:0], cin};
                cout = lhs[W-1];
            end
            OP_RRC: begin
                res  = {cin, lhs[W-1:1]};
                cout = lhs[0];
            end
            OP_SWAP: res = swapped;
            default: res = lhs;
        endcase
    end

endmodule

// File: rtl/blu_wb_ctrl.sv
// Module: blu_wb_ctrl
// Output register stage. Decides which destination and the carry flag are
// written, and registers the result one cycle after the strobe.
// Assumes the result and carry from the core are valid in the strobe cycle.
// An illegal op code holds result and carry and drops every enable.
module blu_wb_ctrl
    import blu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [OP_W-1:0] op_code,
    input  logic            dst_direct,
    input  logic            dst_is_status,
    input  logic [W-1:0]    res_d,
    input  logic            cout_d,
    output logic            res_valid,
    output logic [W-1:0]    result,
    output logic            carry_out,
    output logic            acc_we,
    output logic            dst_we,
    output logic            carry_we
);

    logic legal;
    logic binary;
    logic rot_c;
    logic to_dst;
    logic status_wr;
    logic carry_d;
    logic fire;

    // Decode the write targets for this operation.
    always_comb begin
        legal     = op_is_legal(op_code);
        binary    = op_is_binary(op_code);
        rot_c     = op_uses_carry(op_code);
        to_dst    = binary && dst_direct;
        status_wr = to_dst && dst_is_status;
        carry_d   = status_wr ? res_d[W-1] : cout_d;
        fire      = op_valid && legal;
    end

    // Register the result, carry and one-cycle enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            result    <= '0;
            carry_out <= 1'b0;
            acc_we    <= 1'b0;
            dst_we    <= 1'b0;
            carry_we  <= 1'b0;
        end else if (fire) begin
            res_valid <= 1'b1;
            result    <= res_d;
            carry_out <= carry_d;
            acc_we    <= !to_dst;
            dst_we    <= to_dst;
            carry_we  <= rot_c || status_wr;
        end else begin
            res_valid <= 1'b0;
            acc_we    <= 1'b0;
            dst_we    <= 1'b0;
            carry_we  <= 1'b0;
        end
    end

    // R11: a legal strobe yields a valid result on the next cycle.
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> res_valid);

    // R11: no strobe, no write on the next cycle.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!acc_we && !dst_we && !carry_we && !res_valid));

    // R9: at most one byte destination per operation.
    a_r9_single_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({acc_we, dst_we}));

    // R9: every write comes with a valid result.
    a_r9_write_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we || dst_we || carry_we) |-> res_valid);

    // R10: a carry write needs a carry rotate or a status destination.
    a_r10_carry_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && legal && !rot_c && !status_wr) |=> !carry_we);

    // R12: illegal op codes never produce a result.
    a_r12_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !legal) |=> (!res_valid && $stable(result)));

endmodule

// File: rtl/byte_logic_unit.sv
// Module: byte_logic_unit (top)
// Byte logic and rotate execution unit. It selects operands, computes the
// logic, rotate or swap result, and registers the result and write enables
// one clock after op_valid.
// Assumes fetch, decode, address sequencing and storage lie outside.
module byte_logic_unit
    import blu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_code,
    input  logic             dst_direct,
    input  logic             dst_is_port,
    input  logic             dst_is_status,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [W-1:0]     acc_in,
    input  logic [W-1:0]     dst_mem_in,
    input  logic [W-1:0]     dst_latch_in,
    input  logic [W-1:0]     src_imm,
    input  logic [W-1:0]     src_reg,
    input  logic [W-1:0]     src_dir,
    input  logic [W-1:0]     src_ind,
    input  logic             src_dir_is_port,
    input  logic [W-1:0]     src_pins,
    input  logic             carry_in,
    output logic             res_valid,
    output logic [W-1:0]     result,
    output logic             carry_out,
    output logic             acc_we,
    output logic             dst_we,
    output logic             carry_we
);

    logic [W-1:0] lhs;
    logic [W-1:0] rhs;
    logic [W-1:0] core_res;
    logic         core_cout;
    logic         is_binary;

    // Classify the op for operand selection.
    always_comb begin
        is_binary = op_is_binary(op_code);
    end

    blu_operand_sel #(.W(W)) opsel_i (
        .is_binary       (is_binary),
        .dst_direct      (dst_direct),
        .dst_is_port     (dst_is_port),
        .src_sel         (src_sel),
        .acc_in          (acc_in),
        .dst_mem_in      (dst_mem_in),
        .dst_latch_in    (dst_latch_in),
        .src_imm         (src_imm),
        .src_reg         (src_reg),
        .src_dir         (src_dir),
        .src_ind         (src_ind),
        .src_dir_is_port (src_dir_is_port),
        .src_pins        (src_pins),
        .lhs             (lhs),
        .rhs             (rhs)
    );

    blu_logic_core #(.W(W)) core_i (
        .op   (op_code),
        .lhs  (lhs),
        .rhs  (rhs),
        .cin  (carry_in),
        .res  (core_res),
        .cout (core_cout)
    );

    blu_wb_ctrl #(.W(W)) wb_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .op_valid      (op_valid),
        .op_code       (op_code),
        .dst_direct    (dst_direct),
        .dst_is_status (dst_is_status),
        .res_d         (core_res),
        .cout_d        (core_cout),
        .res_valid     (res_valid),
        .result        (result),
        .carry_out     (carry_out),
        .acc_we        (acc_we),
        .dst_we        (dst_we),
        .carry_we      (carry_we)
    );

    // R3: a plain left rotate carries the accumulator's top bit into bit 0 and leaves carry alone.
    a_r3_rl_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_W'(OP_RL)) |=>
            (result[0] == $past(acc_in[W-1]) && !carry_we && carry_out == $past(carry_in)));

    // R4: the left rotate through carry moves the old carry into bit 0 and bit 7 into carry.
    a_r4_rlc_path: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_W'(OP_RLC)) |=>
            (result[0] == $past(carry_in) && carry_out == $past(acc_in[W-1]) && carry_we));

    // R6: single-operand ops always write the accumulator.
    a_r6_unary_to_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_is_legal(op_code) && !is_binary) |=> (acc_we && !dst_we));

    // R8: a logic op to a port destination reads the latch, so a zero pin byte cannot leak in.
    a_r8_port_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_W'(OP_OR) && dst_direct && dst_is_port) |=>
            ((result & $past(dst_latch_in)) == $past(dst_latch_in)));

endmodule

// File: tb/byte_logic_unit_tb_top.sv
// Bench: near-exhaustive sweep of every legal op over all accumulator values,
// then directed cases for sources, destinations, flags, idle and illegal ops.
module byte_logic_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic       dst_direct = 1'b0;
    logic       dst_is_port = 1'b0;
    logic       dst_is_status = 1'b0;
    logic [1:0] src_sel = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] dst_mem_in = '0;
    logic [7:0] dst_latch_in = '0;
    logic [7:0] src_imm = '0;
    logic [7:0] src_reg = '0;
    logic [7:0] src_dir = '0;
    logic [7:0] src_ind = '0;
    logic       src_dir_is_port = 1'b0;
    logic [7:0] src_pins = '0;
    logic       carry_in = 1'b0;
    logic       res_valid;
    logic [7:0] result;
    logic       carry_out;
    logic       acc_we;
    logic       dst_we;
    logic       carry_we;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_logic_unit dut_i (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
        .dst_direct (dst_direct), .dst_is_port (dst_is_port),
        .dst_is_status (dst_is_status), .src_sel (src_sel), .acc_in (acc_in),
        .dst_mem_in (dst_mem_in), .dst_latch_in (dst_latch_in),
        .src_imm (src_imm), .src_reg (src_reg), .src_dir (src_dir),
        .src_ind (src_ind), .src_dir_is_port (src_dir_is_port),
        .src_pins (src_pins), .carry_in (carry_in), .res_valid (res_valid),
        .result (result), .carry_out (carry_out), .acc_we (acc_we),
        .dst_we (dst_we), .carry_we (carry_we)
    );

    // Observed vector: {valid, acc_we, dst_we, carry_we, carry, result}.
    function automatic logic [12:0] observed();
        return {res_valid, acc_we, dst_we, carry_we, carry_out, result};
    endfunction

    // Reference model written from the requirements.
    function automatic logic [12:0] model(int op, logic [7:0] acc, logic [7:0] mem,
                                          logic [7:0] latch, logic [7:0] b, logic cin,
                                          logic dd, logic dport, logic dstat);
        logic [7:0] a, r;
        logic c, binop, dw, stat, cw;
        binop = (op <= 2);
        a = (binop && dd) ? (dport ? latch : mem) : acc;
        c = cin;
        case (op)
            0: r = a & b;
            1: r = a | b;
            2: r = a ^ b;
            3: r = ~a;
            4: r = 8'h00;
            5: r = {a[6:0], a[7]};
            6: r = {a[0], a[7:1]};
            7: begin r = {a[6:0], cin}; c = a[7]; end
            8: begin r = {cin, a[7:1]}; c = a[0]; end
            default: r = {a[3:0], a[7:4]};
        endcase
        dw   = binop && dd;
        stat = dw && dstat;
        cw   = (op == 7) || (op == 8) || stat;
        if (stat) c = r[7];
        return {1'b1, !dw, dw, cw, c, r};
    endfunction

    task automatic check(string tag, logic [12:0] got, logic [12:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Strobe the currently applied inputs and compare one cycle later.
    task automatic issue(string tag, logic [12:0] exp);
        op_valid = 1'b1;
        @(negedge clk);
        check(tag, observed(), exp);
    endtask

    function automatic string op_tag(int op);
        if (op <= 2) return "R1";
        if (op <= 4) return "R2";
        if (op <= 6) return "R3";
        if (op <= 8) return "R4";
        return "R5";
    endfunction

    initial begin
        logic [12:0] e;
        repeat (3) @(negedge clk);
        // R12: reset state.
        check("R12 reset", observed(), 13'h0);
        rst_n = 1'b1;

        // R1..R5, R6, R7: sweep over ops, accumulator values, operands and carry.
        for (int op = 0; op <= 9; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int k = 0; k < 7; k++) begin
                    for (int c = 0; c < 2; c++) begin
                        logic [7:0] b;
                        b = 8'((k * 37 + a * 3 + 5) & 8'hFF);
                        op_code = 4'(op);
                        acc_in = 8'(a);
                        carry_in = c[0];
                        src_sel = 2'(k % 4);
                        src_imm = ~b; src_reg = ~b; src_dir = ~b; src_ind = ~b;
                        src_dir_is_port = 1'b0;
                        case (k % 4)
                            0: src_imm = b;
                            1: src_reg = b;
                            2: src_dir = b;
                            default: src_ind = b;
                        endcase
                        // Single-operand ops also see dst_direct set (R6).
                        dst_direct = (op > 2) ? k[0] : 1'b0;
                        dst_is_port = 1'b0; dst_is_status = 1'b0;
                        e = model(op, 8'(a), dst_mem_in, dst_latch_in, b, c[0],
                                  dst_direct, 1'b0, 1'b0);
                        issue(op_tag(op), e);
                    end
                end
            end
        end

        // R1/R2: worked sequence FF AND 77 = 77, CPL 77 = 88, 77 OR 88 = FF.
        dst_direct = 0; src_sel = 2'd0; carry_in = 0;
        op_code = 4'd0; acc_in = 8'hFF; src_imm = 8'h77;
        issue("R1 and 77", {5'b11000, 8'h77});
        op_code = 4'd3; acc_in = 8'h77;
        issue("R2 cpl 77", {5'b11000, 8'h88});
        op_code = 4'd1; acc_in = 8'h77; src_imm = 8'h88;
        issue("R1 or 88", {5'b11000, 8'hFF});
        op_code = 4'd4; acc_in = 8'h5A;
        issue("R2 clr", {5'b11000, 8'h00});

        // R6: complement ignores operand and destination select.
        op_code = 4'd3; acc_in = 8'h3C; dst_direct = 1; src_imm = 8'hFF;
        issue("R6 cpl ignores", {5'b11000, 8'hC3});
        op_code = 4'd9; src_sel = 2'd3; src_ind = 8'h11; acc_in = 8'hA5;
        issue("R6 swap ignores", {5'b11000, 8'h5A});

        // R7: a port as source uses pins, not the direct value.
        dst_direct = 0; op_code = 4'd0; acc_in = 8'hFF; src_sel = 2'd2;
        src_dir = 8'hAA; src_pins = 8'h0F; src_dir_is_port = 1;
        issue("R7 pins src", {5'b11000, 8'h0F});
        src_dir_is_port = 0;
        issue("R7 direct src", {5'b11000, 8'hAA});

        // R8/R9: port destination reads the latch, writes the direct location.
        op_code = 4'd0; dst_direct = 1; dst_is_port = 1; src_sel = 2'd0;
        dst_latch_in = 8'hFF; dst_mem_in = 8'h00; src_pins = 8'h00; src_imm = 8'h0F;
        issue("R8 port latch", {5'b10100, 8'h0F});
        dst_is_port = 0; op_code = 4'd1; dst_mem_in = 8'h3C; src_imm = 8'h81;
        issue("R8 memory dst", {5'b10100, 8'hBD});
        op_code = 4'd2; dst_mem_in = 8'hF0; src_imm = 8'hFF; acc_in = 8'h00;
        issue("R9 direct xor", {5'b10100, 8'h0F});

        // R10: status-word destination writes carry from bit 7.
        op_code = 4'd2; dst_is_status = 1; dst_mem_in = 8'h80; src_imm = 8'h00; carry_in = 0;
        issue("R10 status c1", {5'b10111, 8'h80});
        dst_mem_in = 8'h01; carry_in = 1;
        issue("R10 status c0", {5'b10110, 8'h01});
        dst_is_status = 0; carry_in = 1;
        issue("R10 plain dst", {5'b10101, 8'h01});

        // R11: idle cycle drops enables and holds the result.
        op_valid = 0;
        @(negedge clk);
        check("R11 idle", observed(), {5'b00001, 8'h01});

        // R12: illegal op codes give no result.
        for (int op = 10; op < 16; op++) begin
            op_code = 4'(op);
            issue("R12 illegal", {5'b00001, 8'h01});
        end

        op_valid = 0;
        @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule